// File: doc/BRIEF.md
# Dual Instruction Prefetch Buffer

This block sits between a processor's fetch stage and its instruction cache. It keeps two line buffers, each holding the address tag of one aligned instruction line and, when a load is in flight, the number of the request that will fill it. On every cycle with an active fetch, the block aligns the fetch address down to the line size. It then picks the buffer that already holds that line as the current buffer. If neither buffer holds it, buffer 0 is used by default. The other buffer is kept pointed at the next sequential line, so the two buffers alternate as straight-line code runs through them.

Loads go to the cache over a single request port. Each request carries a line address, a request number and the buffer slot that receives it. The cache answers with the request number of each completed load. The core sees a single stall signal. Stall stays high while the current line is missing or still loading, and for a programmable number of extra cycles after a taken branch. When the cache is disabled and cycle accounting is off, the block does nothing and never stalls.

Top module: `ifetch_pair_buf`

## Requirements
- R1: After reset neither buffer holds a line, no request is presented (`req_valid` low), and `stall` is low when no fetch is active.
- R2: The fetch address is aligned down to a line boundary before any compare. The line size is 8 bytes when `wide_line` is 0 and 16 bytes when it is 1.
- R3: A buffer whose tag equals the aligned address becomes the current buffer. If no buffer matches, buffer 0 becomes current.
- R4: On a current-buffer miss, that buffer is retagged and a load is requested with the next request number. Request numbers start at 0 after reset, advance by one per request and wrap modulo 2^ID_W. `stall` stays high until a completion with that number arrives, and it falls in the cycle after that completion.
- R5: The buffer that is not current (slot index current XOR 1) is retagged to the aligned address plus the line size whenever it does not already hold that line, and a load is requested for it. A hit in the current buffer is not stalled by this prefetch.
- R6: When both buffers need a load in the same cycle, the current buffer's request appears on the port in the cycle after the lookup. The prefetch request follows in the next cycle with the following request number.
- R7: A completion marks idle only the buffer whose outstanding number matches it. A completion with any other number leaves `stall` unchanged.
- R8: A branch penalty loaded through `br_valid`/`br_cycles` adds exactly that many stall cycles, counted only on cycles with an active fetch. The penalty is used once and then cleared.
- R9: With `cache_en` and `cycle_acct` both low, a fetch causes no stall and no request, and it leaves buffer tags and request numbering unchanged.

Timing of the request port: every request is registered and appears one cycle after the lookup that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Core presents a fetch address this cycle |
| fetch_addr | input | ADDR_W | Byte address of the fetch |
| wide_line | input | 1 | Line size select: 0 = 8 bytes, 1 = 16 bytes |
| cache_en | input | 1 | Instruction cache enabled |
| cycle_acct | input | 1 | Cycle accounting enabled |
| br_valid | input | 1 | Load a branch penalty |
| br_cycles | input | PEN_W | Penalty length in cycles |
| cpl_valid | input | 1 | Cache reports a completed load |
| cpl_id | input | ID_W | Request number of the completed load |
| req_valid | output | 1 | Load request valid |
| req_addr | output | ADDR_W | Aligned line address to load |
| req_id | output | ID_W | Request number |
| req_slot | output | 1 | Buffer that receives the line |
| stall | output | 1 | Hold the core's fetch |

## Verification
The assertions check on every cycle that the two valid tags never coincide, that a loaded buffer is valid and busy on the following cycle, that a held prefetch request reaches the port on the next cycle, that an inactive fetch produces no request, and that the penalty counter steps down by one per active cycle. Only the bench scenarios can show the choice of buffer, the request addresses and numbers on the port, the exact cycle in which stall falls after a completion, and that stale completion numbers are ignored.

// File: rtl/ifetch_pair_pkg.sv
package ifetch_pair_pkg;
    localparam int ADDR_W = 32;
    localparam int ID_W   = 8;
    localparam int NBUF   = 2;
    localparam int SLOT_W = $clog2(NBUF);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [ID_W-1:0]   id;
        logic [SLOT_W-1:0] slot;
    } load_req_t;

    function automatic logic [ADDR_W-1:0] line_bytes(input logic wide);
        return wide ? ADDR_W'(16) : ADDR_W'(8);
    endfunction

    function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                     input logic wide);
        return a & ~(line_bytes(wide) - ADDR_W'(1));
    endfunction
endpackage

// File: rtl/ifetch_tag_bank.sv
module ifetch_tag_bank
    import ifetch_pair_pkg::*;
#(
    parameter int N = NBUF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      load_en,
    input  logic [ADDR_W-1:0] load_tag [N],
    input  logic [ID_W-1:0]   load_id  [N],
    input  logic              cpl_valid,
    input  logic [ID_W-1:0]   cpl_id,
    output logic [ADDR_W-1:0] tag      [N],
    output logic [N-1:0]      vld,
    output logic [N-1:0]      busy
);
    logic [ID_W-1:0] out_id [N];

    for (genvar i = 0; i < N; i++) begin : g_buf
        always_ff @(posedge clk) begin
            if (rst) begin
                tag[i]    <= '0;
                vld[i]    <= 1'b0;
                busy[i]   <= 1'b0;
                out_id[i] <= '0;
            end else if (load_en[i]) begin
                tag[i]    <= load_tag[i];
                vld[i]    <= 1'b1;
                busy[i]   <= 1'b1;
                out_id[i] <= load_id[i];
            end else if (cpl_valid && busy[i] && cpl_id == out_id[i]) begin
                busy[i]   <= 1'b0;
            end
        end

        a_r4_load_marks_busy: assert property (@(posedge clk) disable iff (rst)
            load_en[i] |=> (vld[i] && busy[i]));
    end

    a_r3_tags_distinct: assert property (@(posedge clk) disable iff (rst)
        (vld[0] && vld[N-1]) |-> (tag[0] != tag[N-1]));
endmodule

// File: rtl/ifetch_select.sv
module ifetch_select
    import ifetch_pair_pkg::*;
#(
    parameter int N = NBUF
) (
    input  logic [ADDR_W-1:0] tag [N],
    input  logic [N-1:0]      vld,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic [ADDR_W-1:0] next_addr,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [SLOT_W-1:0] pre_slot,
    output logic              cur_hit,
    output logic              pre_hit
);
    logic [N-1:0] match;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = vld[i] && (tag[i] == line_addr);
    end

    always_comb begin
        cur_slot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) cur_slot = SLOT_W'(i);
        end
        pre_slot = cur_slot ^ SLOT_W'(1);
        cur_hit  = match[cur_slot];
        pre_hit  = vld[pre_slot] && (tag[pre_slot] == next_addr);
    end
endmodule

// File: rtl/ifetch_req_port.sv
module ifetch_req_port
    import ifetch_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cur_need,
    input  logic              pre_need,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [SLOT_W-1:0] cur_slot,
    input  logic [SLOT_W-1:0] pre_slot,
    output logic [ID_W-1:0]   cur_id,
    output logic [ID_W-1:0]   pre_id,
    output load_req_t         req,
    output logic              held
);
    logic [ID_W-1:0] next_id;
    load_req_t       hold_q;
    load_req_t       cur_r, pre_r;

    assign cur_id = next_id;
    assign pre_id = next_id + ID_W'(cur_need);
    assign held   = hold_q.valid;

    always_comb begin
        cur_r = '{valid: 1'b1, addr: cur_addr, id: cur_id, slot: cur_slot};
        pre_r = '{valid: 1'b1, addr: pre_addr, id: pre_id, slot: pre_slot};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_id <= '0;
            hold_q  <= '0;
            req     <= '0;
        end else begin
            next_id <= next_id + ID_W'(cur_need) + ID_W'(pre_need);
            if (hold_q.valid) begin
                req    <= hold_q;
                hold_q <= '0;
            end else if (cur_need) begin
                req    <= cur_r;
                hold_q <= pre_need ? pre_r : '0;
            end else if (pre_need) begin
                req    <= pre_r;
            end else begin
                req    <= '0;
            end
        end
    end

    a_r6_held_issues_next: assert property (@(posedge clk) disable iff (rst)
        hold_q.valid |=> (req.valid && req.id == $past(hold_q.id)));
    a_r6_held_never_lingers: assert property (@(posedge clk) disable iff (rst)
        hold_q.valid |=> !hold_q.valid);
endmodule

// File: rtl/ifetch_penalty.sv
module ifetch_penalty #(
    parameter int PEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br_valid,
    input  logic [PEN_W-1:0] br_cycles,
    input  logic             active,
    output logic             pending
);
    logic [PEN_W-1:0] left_q;

    assign pending = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst)                   left_q <= '0;
        else if (br_valid)         left_q <= br_cycles;
        else if (active && pending) left_q <= left_q - PEN_W'(1);
    end

    a_r8_counts_down: assert property (@(posedge clk) disable iff (rst)
        (active && pending && !br_valid) |=> (left_q == $past(left_q) - PEN_W'(1)));
    a_r8_holds_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!active && !br_valid) |=> $stable(left_q));
endmodule

// File: rtl/ifetch_pair_buf.sv
module ifetch_pair_buf
    import ifetch_pair_pkg::*;
#(
    parameter int PEN_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              wide_line,
    input  logic              cache_en,
    input  logic              cycle_acct,
    input  logic              br_valid,
    input  logic [PEN_W-1:0]  br_cycles,
    input  logic              cpl_valid,
    input  logic [ID_W-1:0]   cpl_id,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [ID_W-1:0]   req_id,
    output logic              req_slot,
    output logic              stall
);
    logic              active, update, held, pen_pending;
    logic [ADDR_W-1:0] line_addr, next_addr;
    logic [ADDR_W-1:0] tag      [NBUF];
    logic [ADDR_W-1:0] load_tag [NBUF];
    logic [ID_W-1:0]   load_id  [NBUF];
    logic [NBUF-1:0]   vld, busy, load_en;
    logic [SLOT_W-1:0] cur_slot, pre_slot;
    logic              cur_hit, pre_hit, cur_need, pre_need;
    logic [ID_W-1:0]   cur_id, pre_id;
    load_req_t         req;

    assign active    = fetch_valid && (cache_en || cycle_acct);
    assign update    = active && !held;
    assign line_addr = align_down(fetch_addr, wide_line);
    assign next_addr = line_addr + line_bytes(wide_line);
    assign cur_need  = update && !cur_hit;
    assign pre_need  = update && !pre_hit;

    ifetch_select u_sel (
        .tag(tag), .vld(vld), .line_addr(line_addr), .next_addr(next_addr),
        .cur_slot(cur_slot), .pre_slot(pre_slot),
        .cur_hit(cur_hit), .pre_hit(pre_hit)
    );

    always_comb begin
        for (int i = 0; i < NBUF; i++) begin
            load_en[i]  = 1'b0;
            load_tag[i] = line_addr;
            load_id[i]  = cur_id;
            if (cur_need && cur_slot == SLOT_W'(i)) begin
                load_en[i] = 1'b1;
            end else if (pre_need && pre_slot == SLOT_W'(i)) begin
                load_en[i]  = 1'b1;
                load_tag[i] = next_addr;
                load_id[i]  = pre_id;
            end
        end
    end

    ifetch_tag_bank u_bank (
        .clk(clk), .rst(rst), .load_en(load_en), .load_tag(load_tag),
        .load_id(load_id), .cpl_valid(cpl_valid), .cpl_id(cpl_id),
        .tag(tag), .vld(vld), .busy(busy)
    );

    ifetch_req_port u_port (
        .clk(clk), .rst(rst), .cur_need(cur_need), .pre_need(pre_need),
        .cur_addr(line_addr), .pre_addr(next_addr),
        .cur_slot(cur_slot), .pre_slot(pre_slot),
        .cur_id(cur_id), .pre_id(pre_id), .req(req), .held(held)
    );

    ifetch_penalty #(.PEN_W(PEN_W)) u_pen (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_cycles(br_cycles),
        .active(active), .pending(pen_pending)
    );

    assign stall     = active && (pen_pending || held || !cur_hit || busy[cur_slot]);
    assign req_valid = req.valid;
    assign req_addr  = req.addr;
    assign req_id    = req.id;
    assign req_slot  = req.slot[0];

    a_r9_inactive_no_request: assert property (@(posedge clk) disable iff (rst)
        (!active && !held) |=> !req_valid);
    a_r9_inactive_no_stall: assert property (@(posedge clk) disable iff (rst)
        !active |-> !stall);
    a_r2_request_aligned: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_addr[2:0] == 3'b000));
endmodule

// File: tb/ifetch_pair_buf_tb_top.sv
module ifetch_pair_buf_tb_top;
    import ifetch_pair_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              fetch_valid, wide_line, cache_en, cycle_acct;
    logic [ADDR_W-1:0] fetch_addr;
    logic              br_valid;
    logic [3:0]        br_cycles;
    logic              cpl_valid;
    logic [ID_W-1:0]   cpl_id;
    logic              req_valid, req_slot, stall;
    logic [ADDR_W-1:0] req_addr;
    logic [ID_W-1:0]   req_id;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ifetch_pair_buf dut_i (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .wide_line(wide_line), .cache_en(cache_en), .cycle_acct(cycle_acct),
        .br_valid(br_valid), .br_cycles(br_cycles), .cpl_valid(cpl_valid),
        .cpl_id(cpl_id), .req_valid(req_valid), .req_addr(req_addr),
        .req_id(req_id), .req_slot(req_slot), .stall(stall)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_req(input string tag, input logic [31:0] a,
                           input logic [7:0] id, input logic slot);
        chk({tag, " req_valid"}, 64'(req_valid), 64'(1));
        chk({tag, " req_addr"},  64'(req_addr),  64'(a));
        chk({tag, " req_id"},    64'(req_id),    64'(id));
        chk({tag, " req_slot"},  64'(req_slot),  64'(slot));
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; fetch_valid = 0; fetch_addr = '0; wide_line = 1;
        cache_en = 1; cycle_acct = 0; br_valid = 0; br_cycles = '0;
        cpl_valid = 0; cpl_id = '0;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1 stall after reset", 64'(stall), 64'(0));
        chk("R1 no request after reset", 64'(req_valid), 64'(0));
    endtask

    task automatic t_cold_miss();
        fetch_valid = 1; fetch_addr = 32'h1004; wide_line = 1;
        #1 chk("R4 cold miss stalls", 64'(stall), 64'(1));
        step();
        chk_req("R6 current first", 32'h1000, 8'd0, 1'b0);
        chk("R4 still stalled", 64'(stall), 64'(1));
        step();
        chk_req("R5 prefetch next line", 32'h1010, 8'd1, 1'b1);
        chk("R4 stalled while loading", 64'(stall), 64'(1));
        cpl_valid = 1; cpl_id = 8'd0;
        step();
        chk("R4 stall falls after completion", 64'(stall), 64'(0));
        chk("R6 no further request", 64'(req_valid), 64'(0));
        cpl_id = 8'd1;
        step();
        cpl_valid = 0; fetch_valid = 0;
    endtask

    task automatic t_pingpong();
        fetch_valid = 1; fetch_addr = 32'h101C; wide_line = 1;
        #1 chk("R3 hit in buffer 1 no stall", 64'(stall), 64'(0));
        step();
        fetch_valid = 0;
        #1 chk_req("R5 prefetch into buffer 0", 32'h1020, 8'd2, 1'b0);
        cpl_valid = 1; cpl_id = 8'd2;
        step();
        cpl_valid = 0;
    endtask

    task automatic t_narrow_and_stale();
        fetch_valid = 1; fetch_addr = 32'h200C; wide_line = 0;
        #1 chk("R3 no match stalls", 64'(stall), 64'(1));
        step();
        chk_req("R2 R3 8-byte align to buffer 0", 32'h2008, 8'd3, 1'b0);
        step();
        chk_req("R2 8-byte next line", 32'h2010, 8'd4, 1'b1);
        cpl_valid = 1; cpl_id = 8'h77;
        step();
        chk("R7 stale number ignored", 64'(stall), 64'(1));
        cpl_id = 8'd4;
        step();
        chk("R7 prefetch completion leaves current busy", 64'(stall), 64'(1));
        cpl_id = 8'd3;
        step();
        chk("R7 matching completion clears", 64'(stall), 64'(0));
        cpl_valid = 0; fetch_valid = 0;
        step();
    endtask

    task automatic t_penalty();
        br_valid = 1; br_cycles = 4'd3;
        step();
        br_valid = 0;
        fetch_valid = 1; fetch_addr = 32'h2008; wide_line = 0;
        for (int k = 0; k < 3; k++) begin
            #1 chk("R8 penalty stall cycle", 64'(stall), 64'(1));
            step();
        end
        chk("R8 penalty over", 64'(stall), 64'(0));
        step();
        chk("R8 penalty used once", 64'(stall), 64'(0));
        fetch_valid = 0;
        step();
    endtask

    task automatic t_inactive();
        cache_en = 0; cycle_acct = 0;
        fetch_valid = 1; fetch_addr = 32'h9000; wide_line = 0;
        #1 chk("R9 inactive no stall", 64'(stall), 64'(0));
        step();
        chk("R9 inactive no request", 64'(req_valid), 64'(0));
        cycle_acct = 1;
        #1 chk("R9 accounting alone activates", 64'(stall), 64'(1));
        step();
        chk_req("R9 R4 numbering untouched", 32'h9000, 8'd5, 1'b0);
        step();
        chk_req("R6 consecutive number", 32'h9008, 8'd6, 1'b1);
        cpl_valid = 1; cpl_id = 8'd5;
        step();
        cpl_id = 8'd6;
        step();
        cpl_valid = 0; fetch_valid = 0;
    endtask

    initial begin
        t_reset();
        t_cold_miss();
        t_pingpong();
        t_narrow_and_stale();
        t_penalty();
        t_inactive();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule